// File: doc/BRIEF.md
# HDLC Channel Transmitter

This block serialises one 64 kbit/s channel for a microprocessor. Software writes bytes into a transmit FIFO of `DEPTH` bytes. It then issues command strobes: start a message, end a message together with start, and reset the transmitter. On every cycle where the bit-clock enable is high, the block shifts one bit onto a registered serial output. A level output asks for more data whenever the free space in the FIFO exceeds the selected refill threshold. A one-cycle pulse reports that the FIFO ran dry while a message was still being sent.

The block has two modes. In framed mode it wraps the released bytes in flags. It appends a 16-bit frame check sequence and inserts a zero after five consecutive ones in the frame body. In raw mode it shifts the FIFO bytes out unchanged. Between messages the line carries a fill pattern of all ones or repeated flags, chosen by configuration. Bytes are released in blocks: each start command releases everything written so far, and bytes written later wait for the next start.

Top module: `hdlc_chan_tx`

## Requirements
- R1: The FIFO holds `DEPTH` bytes, and a write while it is full is dropped. `tx_req` is high when the free space exceeds `THR_LO` (`cfg_thr_hi`=0) or `THR_HI` (`cfg_thr_hi`=1) and no message end is pending.
- R2: Nothing but fill leaves the block until `cmd_start`. Each start releases only the bytes written up to and including that cycle. Bytes written later are not sent until another start, even if the FIFO holds them.
- R3: In framed mode a message is sent as: an opening flag 0x7E, the released bytes LSB first, a 16-bit check sequence, and a closing flag. The check sequence uses the bit-reflected form of x^16+x^12+x^5+1, preset to 0xFFFF and complemented, and it is sent LSB first. A receiver running the same check over the bytes and the sequence ends on the residue 0xF0B8.
- R4: `cmd_start` with `cmd_end` in the same cycle marks the message end. The block sends every released byte, then the check sequence and the closing flag, then returns to fill. `tx_req` stays low while the end is pending and rises once the closing flag is out.
- R5: In framed mode a 0 follows every five consecutive 1s in the bytes and the check sequence. The flags are never altered.
- R6: Between messages `tx_bit` carries all ones (`cfg_fill_flags`=0) or back-to-back 0x7E flags (`cfg_fill_flags`=1).
- R7: If no released byte is left while a message without a pending end is being sent, the block does four things. It pulses `tx_udr` for one cycle, empties the FIFO (unreleased bytes included), returns to fill, and raises `tx_req`.
- R8: `cmd_reset` aborts any message in progress, empties the FIFO, returns the line to fill and leaves `tx_req` high. It does not pulse `tx_udr`.
- R9: In raw mode (`cfg_transparent`=1) bytes go out LSB first with no flags, no check sequence and no zero insertion. A start with end returns to fill after the last byte. Running dry without an end pulses `tx_udr` as in R7.
- R10: After `rst`, `tx_bit` is 1, `tx_req` is 1 and `tx_udr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-clock enable, one serial bit per high cycle |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | Byte to write |
| cmd_start | input | 1 | Message-start command strobe |
| cmd_end | input | 1 | Message-end command, taken only together with cmd_start |
| cmd_reset | input | 1 | Transmitter-reset command strobe |
| cfg_transparent | input | 1 | 1 selects raw mode, 0 framed mode |
| cfg_fill_flags | input | 1 | 1 selects flag fill, 0 all-ones fill |
| cfg_thr_hi | input | 1 | 1 selects THR_HI, 0 selects THR_LO |
| tx_bit | output | 1 | Registered serial output |
| tx_req | output | 1 | Data request: free space above threshold |
| tx_udr | output | 1 | One-cycle transmit underrun pulse |

## Verification
The bench builds the block with `DEPTH`=16, `THR_LO`=8 and `THR_HI`=12, so a handful of writes moves the FIFO across both thresholds. Eighteen writes overflow it, which exposes dropped writes as a short raw stream. A bit-level receiver model in the bench removes the inserted zeros, finds the flags and checks the residue. This means stuffing inside both the payload and the check sequence, aborted frames and flushed unreleased bytes all show up as decoded frame contents. The default depth of 128 with thresholds 64 and 96 is only elaborated.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    S_FILL,
    S_OPEN,
    S_BODY,
    S_FCS,
    S_CLOSE,
    S_RAW
  } tx_state_e;

  localparam logic [7:0]  FLAG_BYTE    = 8'h7E;
  localparam logic [15:0] FCS_POLY_REV = 16'h8408;
  localparam logic [15:0] FCS_PRESET   = 16'hFFFF;

  // One bit of the reflected CRC-16, LSB-first data order
  function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic b);
    logic [15:0] s;
    s = {1'b0, c[15:1]};
    if (c[0] ^ b) s = s ^ FCS_POLY_REV;
    return s;
  endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 128  // power of two
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push_req,
  input  logic [7:0]                   push_data,
  input  logic                         pop,
  output logic [7:0]                   pop_data,
  output logic                         pushed,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign pushed   = push_req && (level != FULL) && !flush;
  assign pop_data = mem[rp];

  always_ff @(posedge clk) begin
    if (pushed) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (pushed) wp <= wp + 1'b1;
      if (pop)    rp <= rp + 1'b1;
      level <= level + CW'(pushed) - CW'(pop);
    end
  end

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> level != '0);

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl #(
  parameter int DEPTH  = 128,
  parameter int THR_LO = 64,
  parameter int THR_HI = 96
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_start,
  input  logic                         cmd_end,
  input  logic                         cmd_reset,
  input  logic                         cfg_thr_hi,
  input  logic [$clog2(DEPTH+1)-1:0]   level,
  input  logic                         pushed,
  input  logic                         pop,
  input  logic                         udr,
  input  logic                         done,
  output logic                         flush,
  output logic                         rel_avail,
  output logic                         go,
  output logic                         endp,
  output logic                         req
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] rel_q;
  logic [CW-1:0] thr;
  logic [CW-1:0] free_sp;

  assign flush     = cmd_reset || udr;
  assign rel_avail = (rel_q != '0);
  assign thr       = cfg_thr_hi ? CW'(THR_HI) : CW'(THR_LO);
  assign free_sp   = FULL - level;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q <= '0;
      go    <= 1'b0;
      endp  <= 1'b0;
      req   <= 1'b1;
    end else begin
      if (flush)          rel_q <= '0;
      else if (cmd_start) rel_q <= level + CW'(pushed) - CW'(pop);
      else                rel_q <= rel_q - CW'(pop);

      if (flush)          go <= 1'b0;
      else if (cmd_start) go <= 1'b1;
      else if (done)      go <= 1'b0;

      if (flush)                     endp <= 1'b0;
      else if (cmd_start && cmd_end) endp <= 1'b1;
      else if (done)                 endp <= 1'b0;

      req <= (free_sp > thr) && !endp;
    end
  end

  // R2
  rel_le_level_chk: assert property (@(posedge clk) disable iff (rst)
    rel_q <= level);

  // R8
  abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |=> !go && !endp);

endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       cfg_transparent,
  input  logic       cfg_fill_flags,
  input  logic       abort,
  input  logic       go,
  input  logic       endp,
  input  logic       rel_avail,
  input  logic [7:0] pop_data,
  output logic       pop,
  output logic       udr,
  output logic       done,
  output logic       tx_bit
);
  tx_state_e   st, st_n;
  logic [7:0]  sh, sh_n;
  logic [15:0] crc, crc_n;
  logic [3:0]  cnt, cnt_n;
  logic [2:0]  ones, ones_n;
  logic        bit_n;

  always_comb begin
    st_n   = st;
    sh_n   = sh;
    crc_n  = crc;
    cnt_n  = cnt;
    ones_n = ones;
    bit_n  = tx_bit;
    pop    = 1'b0;
    udr    = 1'b0;
    done   = 1'b0;
    if (bit_en) begin
      case (st)
        S_FILL: begin
          bit_n = cfg_fill_flags ? FLAG_BYTE[cnt[2:0]] : 1'b1;
          cnt_n = {1'b0, cnt[2:0] + 3'd1};
          if ((cnt[2:0] == 3'd7 || !cfg_fill_flags) && go && rel_avail) begin
            cnt_n = '0;
            if (cfg_transparent) begin
              st_n = S_RAW;
              pop  = 1'b1;
              sh_n = pop_data;
            end else begin
              st_n = S_OPEN;
            end
          end
        end
        S_OPEN: begin
          bit_n = FLAG_BYTE[cnt[2:0]];
          cnt_n = cnt + 4'd1;
          if (cnt[2:0] == 3'd7) begin
            cnt_n  = '0;
            ones_n = '0;
            crc_n  = FCS_PRESET;
            if (rel_avail) begin
              pop  = 1'b1;
              sh_n = pop_data;
              st_n = S_BODY;
            end else if (endp) begin
              st_n  = S_FCS;
              crc_n = ~FCS_PRESET;
            end else begin
              udr  = 1'b1;
              st_n = S_FILL;
            end
          end
        end
        S_BODY: begin
          if (ones == 3'd5) begin
            bit_n  = 1'b0;
            ones_n = '0;
          end else begin
            bit_n  = sh[0];
            sh_n   = {1'b0, sh[7:1]};
            crc_n  = fcs_step(crc, sh[0]);
            ones_n = sh[0] ? ones + 3'd1 : 3'd0;
            cnt_n  = cnt + 4'd1;
            if (cnt[2:0] == 3'd7) begin
              cnt_n = '0;
              if (rel_avail) begin
                pop  = 1'b1;
                sh_n = pop_data;
              end else if (endp) begin
                st_n  = S_FCS;
                crc_n = ~fcs_step(crc, sh[0]);
              end else begin
                udr  = 1'b1;
                st_n = S_FILL;
              end
            end
          end
        end
        S_FCS: begin
          if (ones == 3'd5) begin
            bit_n  = 1'b0;
            ones_n = '0;
          end else begin
            bit_n  = crc[0];
            crc_n  = {1'b0, crc[15:1]};
            ones_n = crc[0] ? ones + 3'd1 : 3'd0;
            cnt_n  = cnt + 4'd1;
            if (cnt == 4'd15) begin
              cnt_n = '0;
              st_n  = S_CLOSE;
            end
          end
        end
        S_CLOSE: begin
          if (ones == 3'd5) begin
            bit_n  = 1'b0;
            ones_n = '0;
          end else begin
            bit_n  = FLAG_BYTE[cnt[2:0]];
            ones_n = '0;
            cnt_n  = cnt + 4'd1;
            if (cnt[2:0] == 3'd7) begin
              cnt_n = '0;
              st_n  = S_FILL;
              done  = 1'b1;
            end
          end
        end
        S_RAW: begin
          bit_n = sh[0];
          sh_n  = {1'b0, sh[7:1]};
          cnt_n = cnt + 4'd1;
          if (cnt[2:0] == 3'd7) begin
            cnt_n = '0;
            if (rel_avail) begin
              pop  = 1'b1;
              sh_n = pop_data;
            end else if (endp) begin
              st_n = S_FILL;
              done = 1'b1;
            end else begin
              udr  = 1'b1;
              st_n = S_FILL;
            end
          end
        end
        default: st_n = S_FILL;
      endcase
    end
    if (abort) begin
      pop  = 1'b0;
      udr  = 1'b0;
      done = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_FILL;
      sh     <= '0;
      crc    <= FCS_PRESET;
      cnt    <= '0;
      ones   <= '0;
      tx_bit <= 1'b1;
    end else begin
      tx_bit <= bit_n;
      sh     <= sh_n;
      crc    <= crc_n;
      if (abort) begin
        st   <= S_FILL;
        cnt  <= '0;
        ones <= '0;
      end else begin
        st   <= st_n;
        cnt  <= cnt_n;
        ones <= ones_n;
      end
    end
  end

  // Checker: length of the current run of body ones seen on tx_bit
  logic       en_q, body_q;
  logic [2:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      body_q <= 1'b0;
      run_q  <= '0;
    end else begin
      en_q <= bit_en;
      if (bit_en) body_q <= (st == S_BODY) || (st == S_FCS);
      if (en_q) run_q <= (body_q && tx_bit) ? ((run_q == 3'd7) ? 3'd7 : run_q + 3'd1) : 3'd0;
    end
  end

  // R5
  ones_run_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= 3'd5);

  // R4
  udr_no_end_chk: assert property (@(posedge clk) disable iff (rst)
    udr |-> !endp);

endmodule

// File: rtl/hdlc_chan_tx.sv
module hdlc_chan_tx #(
  parameter int DEPTH  = 128,
  parameter int THR_LO = 64,
  parameter int THR_HI = 96
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cmd_start,
  input  logic       cmd_end,
  input  logic       cmd_reset,
  input  logic       cfg_transparent,
  input  logic       cfg_fill_flags,
  input  logic       cfg_thr_hi,
  output logic       tx_bit,
  output logic       tx_req,
  output logic       tx_udr
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          flush, pushed, pop, udr, done;
  logic          rel_avail, go, endp;
  logic [7:0]    pop_data;
  logic [CW-1:0] level;

  hdlc_tx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .flush(flush),
    .push_req(wr_en), .push_data(wr_data),
    .pop(pop), .pop_data(pop_data),
    .pushed(pushed), .level(level)
  );

  hdlc_tx_ctrl #(.DEPTH(DEPTH), .THR_LO(THR_LO), .THR_HI(THR_HI)) ctrl_i (
    .clk(clk), .rst(rst),
    .cmd_start(cmd_start), .cmd_end(cmd_end), .cmd_reset(cmd_reset),
    .cfg_thr_hi(cfg_thr_hi), .level(level), .pushed(pushed), .pop(pop),
    .udr(udr), .done(done), .flush(flush), .rel_avail(rel_avail),
    .go(go), .endp(endp), .req(tx_req)
  );

  hdlc_tx_ser ser_i (
    .clk(clk), .rst(rst), .bit_en(bit_en),
    .cfg_transparent(cfg_transparent), .cfg_fill_flags(cfg_fill_flags),
    .abort(cmd_reset), .go(go), .endp(endp), .rel_avail(rel_avail),
    .pop_data(pop_data), .pop(pop), .udr(udr), .done(done),
    .tx_bit(tx_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_udr <= 1'b0;
    else     tx_udr <= udr;
  end

  // R7
  flush_on_udr_chk: assert property (@(posedge clk) disable iff (rst)
    tx_udr |-> level == '0);

endmodule

// File: tb/hdlc_chan_tx_tb_top.sv
module hdlc_chan_tx_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic cmd_start = 1'b0, cmd_end = 1'b0, cmd_reset = 1'b0;
  logic cfg_transparent = 1'b0, cfg_fill_flags = 1'b0, cfg_thr_hi = 1'b0;
  logic tx_bit, tx_req, tx_udr;

  always #2.5 clk = ~clk;

  hdlc_chan_tx #(.DEPTH(DEPTH), .THR_LO(8), .THR_HI(12)) dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_start(cmd_start), .cmd_end(cmd_end), .cmd_reset(cmd_reset),
    .cfg_transparent(cfg_transparent), .cfg_fill_flags(cfg_fill_flags),
    .cfg_thr_hi(cfg_thr_hi), .tx_bit(tx_bit), .tx_req(tx_req), .tx_udr(tx_udr)
  );

  int nchk = 0, nfail = 0, udr_cnt = 0;

  // bit-clock enable every second cycle
  always @(negedge clk) bit_en <= ~bit_en;

  // log of serial bits
  logic line_log [0:16383];
  int   lg_n = 0;
  logic en_seen = 1'b0;
  always @(posedge clk) begin
    en_seen <= bit_en && !rst;
    if (tx_udr) udr_cnt <= udr_cnt + 1;
  end
  always @(negedge clk) begin
    if (en_seen && lg_n < 16384) begin
      line_log[lg_n] = tx_bit;
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd(input logic s, input logic e, input logic r);
    cmd_start = s; cmd_end = e; cmd_reset = r;
    @(negedge clk);
    cmd_start = 1'b0; cmd_end = 1'b0; cmd_reset = 1'b0;
  endtask

  // ---- receiver model ----
  int nfr, nbad;
  int fr_len [0:7];
  logic [7:0] fr_b [0:7][0:39];
  logic bb [0:1023];

  task automatic decode(input int from);
    int ones, blen;
    bit inf;
    logic [15:0] c;
    nfr = 0; nbad = 0; ones = 0; blen = 0; inf = 0;
    for (int i = from; i < lg_n; i++) begin
      logic b;
      b = line_log[i];
      if (ones == 5 && b == 1'b0) begin
        ones = 0;
      end else if (ones == 6 && b == 1'b0) begin
        blen = (blen >= 7) ? blen - 7 : 0;
        if (inf && blen > 0) begin
          if (blen % 8 == 0 && blen >= 24 && nfr < 8) begin
            c = 16'hFFFF;
            for (int k = 0; k < blen; k++) begin
              logic [15:0] s;
              s = {1'b0, c[15:1]};
              if (c[0] ^ bb[k]) s = s ^ 16'h8408;
              c = s;
            end
            if (c == 16'hF0B8) begin
              fr_len[nfr] = blen / 8 - 2;
              for (int y = 0; y < blen / 8 - 2 && y < 40; y++)
                for (int q = 0; q < 8; q++) fr_b[nfr][y][q] = bb[y*8+q];
              nfr++;
            end else nbad++;
          end else nbad++;
        end
        inf = 1; blen = 0; ones = 0;
      end else begin
        if (b) begin
          ones = (ones < 7) ? ones + 1 : 7;
          if (ones == 7) inf = 0;
        end else ones = 0;
        if (blen < 1024) begin bb[blen] = b; blen++; end
      end
    end
  endtask

  logic [7:0] rb [0:31];
  int tail_zeros;
  task automatic raw_bytes(input int from, input int n);
    int p;
    p = from;
    while (p < lg_n && line_log[p] == 1'b1) p++;
    for (int k = 0; k < n; k++)
      for (int q = 0; q < 8; q++) rb[k][q] = (p + k*8 + q < lg_n) ? line_log[p + k*8 + q] : 1'b1;
    tail_zeros = 0;
    for (int i = p + n*8; i < lg_n; i++) if (!line_log[i]) tail_zeros++;
  endtask

  function automatic int zeros_from(input int from);
    int z = 0;
    for (int i = from; i < lg_n; i++) if (!line_log[i]) z++;
    return z;
  endfunction

  // ---- scenarios ----
  task automatic t_reset;
    chk(tx_bit == 1'b1, "R10 tx_bit after reset", tx_bit, 1);
    chk(tx_req == 1'b1, "R10 tx_req after reset", tx_req, 1);
    chk(udr_cnt == 0, "R10 tx_udr after reset", udr_cnt, 0);
  endtask

  task automatic t_level;
    int m;
    cfg_fill_flags = 1'b0; cfg_thr_hi = 1'b0;
    m = lg_n;
    for (int i = 0; i < 7; i++) put(8'h40 + 8'(i));
    idle(3);
    chk(tx_req == 1'b1, "R1 free 9 above low threshold", tx_req, 1);
    put(8'h55); idle(3);
    chk(tx_req == 1'b0, "R1 free 8 not above low threshold", tx_req, 0);
    cmd(1'b0, 1'b0, 1'b1); idle(3);
    chk(tx_req == 1'b1, "R8 reset empties FIFO", tx_req, 1);
    cfg_thr_hi = 1'b1;
    for (int i = 0; i < 3; i++) put(8'h60);
    idle(3);
    chk(tx_req == 1'b1, "R1 free 13 above high threshold", tx_req, 1);
    put(8'h61); idle(3);
    chk(tx_req == 1'b0, "R1 free 12 not above high threshold", tx_req, 0);
    cmd(1'b0, 1'b0, 1'b1); idle(3);
    cfg_thr_hi = 1'b0;
    idle(20);
    chk(zeros_from(m) == 0, "R2 R6 only ones fill without start", zeros_from(m), 0);
  endtask

  task automatic t_flags;
    int m, u0;
    logic [7:0] pl [0:5];
    pl[0] = 8'h12; pl[1] = 8'hFF; pl[2] = 8'hFF; pl[3] = 8'h7E; pl[4] = 8'hF8; pl[5] = 8'h01;
    cfg_fill_flags = 1'b1; idle(40);
    m = lg_n; u0 = udr_cnt;
    for (int i = 0; i < 6; i++) put(pl[i]);
    cmd(1'b1, 1'b1, 1'b0);
    idle(20);
    chk(tx_req == 1'b0, "R4 request held low while end pending", tx_req, 0);
    idle(500);
    decode(m);
    chk(nfr == 1 && nbad == 0, "R3 one valid framed message", nfr, 1);
    chk(fr_len[0] == 6, "R3 frame length", fr_len[0], 6);
    for (int i = 0; i < 6; i++)
      chk(fr_b[0][i] == pl[i], "R5 R3 payload byte after destuffing", fr_b[0][i], pl[i]);
    chk(tx_req == 1'b1, "R4 request after closing flag", tx_req, 1);
    chk(udr_cnt == u0, "R4 clean end no underrun", udr_cnt, u0);
    begin
      bit seen = 0;
      for (int i = lg_n - 40; i < lg_n - 8; i++) begin
        logic [7:0] w;
        for (int q = 0; q < 8; q++) w[q] = line_log[i+q];
        if (w == 8'h7E) seen = 1;
      end
      chk(seen, "R6 flag fill after message", seen, 1);
    end
  endtask

  task automatic t_blocks;
    int m;
    cfg_fill_flags = 1'b0; idle(20);
    m = lg_n;
    for (int i = 0; i < 4; i++) put(8'hA0 + 8'(i));
    idle(40);
    chk(zeros_from(m) == 0, "R2 no output before start", zeros_from(m), 0);
    cmd(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) put(8'hB0 + 8'(i));
    cmd(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) put(8'hC0 + 8'(i));
    cmd(1'b1, 1'b1, 1'b0);
    idle(600);
    decode(m);
    chk(nfr == 1, "R2 blocks joined in one frame", nfr, 1);
    chk(fr_len[0] == 11, "R2 all blocks sent", fr_len[0], 11);
    chk(fr_b[0][4] == 8'hB0 && fr_b[0][10] == 8'hC2, "R2 block order", fr_b[0][10], 8'hC2);
  endtask

  task automatic t_underrun;
    int m, u0;
    cfg_fill_flags = 1'b0; idle(20);
    m = lg_n; u0 = udr_cnt;
    for (int i = 0; i < 3; i++) put(8'h31 + 8'(i));
    cmd(1'b1, 1'b0, 1'b0);
    put(8'hE1); put(8'hE2);
    idle(400);
    chk(udr_cnt == u0 + 1, "R7 underrun pulse despite unreleased bytes", udr_cnt, u0 + 1);
    decode(m);
    chk(nfr == 0, "R7 no valid frame after underrun", nfr, 0);
    chk(zeros_from(lg_n - 60) == 0, "R7 ones fill after underrun", zeros_from(lg_n - 60), 0);
    chk(tx_req == 1'b1, "R7 request after underrun", tx_req, 1);
    m = lg_n;
    put(8'hA5);
    cmd(1'b1, 1'b1, 1'b0);
    idle(300);
    decode(m);
    chk(nfr == 1 && fr_len[0] == 1 && fr_b[0][0] == 8'hA5, "R7 FIFO flushed by underrun", fr_len[0], 1);
  endtask

  task automatic t_abort;
    int m, u0;
    cfg_fill_flags = 1'b1; idle(30);
    m = lg_n; u0 = udr_cnt;
    for (int i = 0; i < 8; i++) put(8'h11 * 8'(i + 1));
    cmd(1'b1, 1'b0, 1'b0);
    idle(60);
    cmd(1'b0, 1'b0, 1'b1);
    idle(2);
    chk(tx_req == 1'b1, "R8 FIFO empty after reset command", tx_req, 1);
    idle(200);
    decode(m);
    chk(nfr == 0, "R8 aborted frame not valid", nfr, 0);
    chk(udr_cnt == u0, "R8 no underrun on reset", udr_cnt, u0);
    m = lg_n;
    put(8'h5A); put(8'hC3);
    cmd(1'b1, 1'b1, 1'b0);
    idle(300);
    decode(m);
    chk(nfr == 1 && fr_len[0] == 2 && fr_b[0][1] == 8'hC3, "R8 only new bytes after reset", fr_len[0], 2);
  endtask

  task automatic t_raw;
    int m, u0;
    logic [7:0] pl [0:4];
    pl[0] = 8'h3C; pl[1] = 8'hFF; pl[2] = 8'h7E; pl[3] = 8'hFF; pl[4] = 8'h81;
    cfg_transparent = 1'b1; cfg_fill_flags = 1'b0; idle(20);
    m = lg_n; u0 = udr_cnt;
    for (int i = 0; i < 5; i++) put(pl[i]);
    cmd(1'b1, 1'b1, 1'b0);
    idle(250);
    raw_bytes(m, 5);
    for (int i = 0; i < 5; i++)
      chk(rb[i] == pl[i], "R9 raw byte unchanged", rb[i], pl[i]);
    chk(tail_zeros == 0 && udr_cnt == u0, "R9 fill after raw end", tail_zeros, 0);
    m = lg_n;
    for (int i = 0; i < 18; i++) put(8'h10 + 8'(i));
    idle(2);
    chk(tx_req == 1'b0, "R1 full FIFO no request", tx_req, 0);
    cmd(1'b1, 1'b1, 1'b0);
    idle(450);
    raw_bytes(m, 16);
    for (int i = 0; i < 16; i++)
      chk(rb[i] == 8'h10 + 8'(i), "R1 stored bytes of full FIFO", rb[i], 8'h10 + 8'(i));
    chk(tail_zeros == 0, "R1 writes beyond depth dropped", tail_zeros, 0);
    m = lg_n; u0 = udr_cnt;
    put(8'h22); put(8'h44);
    cmd(1'b1, 1'b0, 1'b0);
    idle(150);
    raw_bytes(m, 2);
    chk(rb[0] == 8'h22 && rb[1] == 8'h44, "R9 raw bytes before underrun", rb[1], 8'h44);
    chk(udr_cnt == u0 + 1, "R9 raw underrun pulse", udr_cnt, u0 + 1);
    chk(tail_zeros == 0, "R9 ones fill after raw underrun", tail_zeros, 0);
    cfg_transparent = 1'b0;
  endtask

  initial begin
    #(150000 * 5);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", lg_n, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(10);
    t_reset;
    t_level;
    t_flags;
    t_blocks;
    t_underrun;
    t_abort;
    t_raw;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule